// File: doc/BRIEF.md
# ADC Acquire/Convert Sequencer

This block sequences the two phases of a successive-approximation converter: a sample-and-hold acquisition window followed by a fixed-length conversion. Every duration is measured in conversion-clock ticks. A tick is a single-cycle strobe on `tick`, synchronous to the system clock. The converter itself is modelled as a 10-bit digital input. That input is latched when a conversion begins, and the latched value is written to the result buffer once the conversion time has elapsed.

Acquisition starts when the block is enabled and the sample-request bit is set. A 3-bit source select then decides what ends acquisition and starts the conversion:
- the software releasing the sample bit;
- a timer event;
- an external event;
- an automatic count of ticks.

In the automatic mode, acquisition resumes by itself after each result. Dropping the enable during a conversion aborts it. The buffer is left untouched, and a short recovery period must pass before a new acquisition can begin. A bus write port can also load the buffer directly.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `sh_sample`, `busy` and `done` are low and `result` is zero.
- R2: With `enable` high and `samp_req` high while idle, `sh_sample` rises on the next cycle. With `trig_sel` = 3'b000, the first clock edge that sees `samp_req` low during acquisition moves the block to conversion, so `busy` is high one cycle later.
- R3: With `trig_sel` = 3'b111, conversion starts on the N-th tick counted from the start of acquisition, where N = `auto_cnt`, and an `auto_cnt` of 0 is treated as 1. After each completed conversion, `sh_sample` rises again on the next cycle.
- R4: With `trig_sel` = 3'b001, only a `timer_evt` pulse during acquisition starts conversion. With 3'b010, only an `ext_evt` pulse does. In each of these modes, the event that is not selected and the release of `samp_req` have no effect. Codes 3'b011 to 3'b110 never start a conversion.
- R5: `busy` is high for exactly 15 ticks. `result` then takes the value `adc_in` had on the cycle the conversion started, and `done` pulses high for one cycle together with that update.
- R6: Driving `enable` low during a conversion ends it: `busy` and `sh_sample` go low, no `done` pulse follows, and `result` keeps its previous contents.
- R7: If `enable` is low on the same edge that an automatic start would occur, no conversion starts.
- R8: After an abort, `sh_sample` stays low until 2 ticks have passed, even if `enable` and `samp_req` are both high.
- R9: `bus_wr` loads `bus_wdata` into `result` on the next edge. A conversion completing later overwrites it. On a coincident edge, the conversion result wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Conversion-clock strobe, one cycle per tick |
| enable | input | 1 | Converter enable; low aborts and stops sampling |
| samp_req | input | 1 | Sample-request bit |
| trig_sel | input | 3 | Conversion trigger source select |
| auto_cnt | input | 5 | Acquisition length in ticks for automatic mode |
| timer_evt | input | 1 | Timer trigger event |
| ext_evt | input | 1 | External trigger event |
| adc_in | input | 10 | Converter data, latched at conversion start |
| bus_wr | input | 1 | Bus write strobe for the result buffer |
| bus_wdata | input | 10 | Bus write data |
| sh_sample | output | 1 | Sample-and-hold acquiring |
| busy | output | 1 | Conversion in progress |
| result | output | 10 | Result buffer |
| done | output | 1 | One-cycle pulse when a result is written |

## Verification
Each trigger source is driven with both its own event and the competing ones. A timer pulse in external mode must do nothing, and an external pulse in timer mode must do nothing; this separates a correct source decode from one that accepts any event. The converter input is changed while a conversion is running, which separates latching at the start from sampling at the end. Tick counts are taken while `busy` and `sh_sample` are high, and automatic counts of 3 and 0 expose off-by-one errors and a missing minimum. Disable is applied in three positions: mid-conversion, coincident with an automatic start, and followed at once by a new sample request. Together these separate abort priority from the recovery wait.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int DW          = 10,
  parameter int SCW         = 5,
  parameter int CONV_TICKS  = 15,
  parameter int RECOV_TICKS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          enable,
  input  logic          samp_req,
  input  logic [2:0]    trig_sel,
  input  logic [SCW-1:0] auto_cnt,
  input  logic          timer_evt,
  input  logic          ext_evt,
  input  logic [DW-1:0] adc_in,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic          sh_sample,
  output logic          busy,
  output logic [DW-1:0] result,
  output logic          done
);
  localparam int CCW = $clog2(CONV_TICKS + 1);
  localparam int CW  = (SCW + 1 > CCW) ? SCW + 1 : CCW;
  localparam logic [2:0] SRC_SW = 3'd0, SRC_TMR = 3'd1, SRC_EXT = 3'd2, SRC_AUTO = 3'd7;

  typedef enum logic [1:0] {S_IDLE, S_SAMP, S_CONV, S_RCV} st_t;
  st_t st;
  logic [CW-1:0] cnt;
  logic [DW-1:0] hold;
  logic [CW-1:0] lim;
  logic          trig, fin;

  assign lim       = (auto_cnt == '0) ? CW'(1) : CW'(auto_cnt);
  assign sh_sample = (st == S_SAMP);
  assign busy      = (st == S_CONV);
  assign fin       = busy && enable && tick && (cnt == CW'(CONV_TICKS - 1));

  always_comb begin
    case (trig_sel)
      SRC_SW:   trig = !samp_req;
      SRC_TMR:  trig = timer_evt;
      SRC_EXT:  trig = ext_evt;
      SRC_AUTO: trig = tick && ((cnt + CW'(1)) >= lim);
      default:  trig = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      hold   <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (bus_wr) result <= bus_wdata;
      case (st)
        S_IDLE: if (enable && samp_req) begin
          st  <= S_SAMP;
          cnt <= '0;
        end
        S_SAMP: begin
          if (!enable) st <= S_IDLE;
          else if (trig) begin
            st   <= S_CONV;
            cnt  <= '0;
            hold <= adc_in;
          end else if (tick && trig_sel == SRC_AUTO) cnt <= cnt + CW'(1);
        end
        S_CONV: begin
          if (!enable) begin
            st  <= S_RCV;
            cnt <= '0;
          end else if (fin) begin
            result <= hold;
            done   <= 1'b1;
            cnt    <= '0;
            st     <= (trig_sel == SRC_AUTO) ? S_SAMP : S_IDLE;
          end else if (tick) cnt <= cnt + CW'(1);
        end
        default: if (tick) begin
          if (cnt == CW'(RECOV_TICKS - 1)) st <= S_IDLE;
          else cnt <= cnt + CW'(1);
        end
      endcase
    end
  end

  AST_SW_START: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_sample && enable && trig_sel == SRC_SW && !samp_req) |=> busy); // R2
  AST_AUTO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && trig_sel == SRC_AUTO) |=> sh_sample); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy)); // R5
  AST_ABORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !enable && !bus_wr) |=> (!done && !busy && $stable(result))); // R6
  AST_NO_START_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_sample && !enable) |=> !busy); // R7
  AST_RECOV_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RCV) |=> !sh_sample); // R8
  AST_BUS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !fin) |=> (result == $past(bus_wdata))); // R9
endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, enable = 0, samp_req = 0, timer_evt = 0, ext_evt = 0, bus_wr = 0;
  logic [2:0] trig_sel = 3'd0;
  logic [4:0] auto_cnt = 5'd0;
  logic [9:0] adc_in = '0, bus_wdata = '0;
  logic sh_sample, busy, done;
  logic [9:0] result;
  int n_chk = 0, n_bad = 0;
  int busy_ticks = 0, samp_ticks = 0, done_cnt = 0;

  always #10 clk = ~clk;

  adc_seq_ctrl dut_i (.clk(clk), .rst_n(rst_n), .tick(tick), .enable(enable), .samp_req(samp_req),
    .trig_sel(trig_sel), .auto_cnt(auto_cnt), .timer_evt(timer_evt), .ext_evt(ext_evt),
    .adc_in(adc_in), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .sh_sample(sh_sample),
    .busy(busy), .result(result), .done(done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input bit t);
    @(negedge clk);
    tick = t;
    if (busy && tick) busy_ticks++;
    if (sh_sample && tick) samp_ticks++;
    if (done) done_cnt++;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      cyc(1); cyc(0); cyc(0);
    end
  endtask

  task automatic clr();
    busy_ticks = 0; samp_ticks = 0; done_cnt = 0;
  endtask

  task automatic t_reset();
    chk(!sh_sample && !busy && !done, "R1 outputs", {sh_sample, busy, done}, 0);
    chk(result == 0, "R1 result", result, 0);
  endtask

  task automatic t_software();
    trig_sel = 3'd0; enable = 1; samp_req = 1; adc_in = 10'h2A5;
    cyc(0); cyc(0);
    chk(sh_sample && !busy, "R2 acquiring", {sh_sample, busy}, 2);
    samp_req = 0; clr();
    cyc(0);
    chk(busy == 1, "R2 start on release", busy, 1);
    adc_in = 10'h0F0;
    run(16);
    chk(busy_ticks == 15, "R5 busy ticks", busy_ticks, 15);
    chk(done_cnt == 1, "R5 done pulses", done_cnt, 1);
    chk(result == 10'h2A5, "R5 latched value", result, 10'h2A5);
    chk(!busy && !sh_sample, "R2 idle after", {busy, sh_sample}, 0);
  endtask

  task automatic t_auto();
    trig_sel = 3'd7; auto_cnt = 5'd3; adc_in = 10'h1C3; samp_req = 1;
    cyc(0);
    samp_req = 0; clr();
    run(3);
    chk(samp_ticks == 3, "R3 sample ticks", samp_ticks, 3);
    chk(busy == 1, "R3 auto start", busy, 1);
    adc_in = 10'h3FF; clr();
    run(16);
    chk(busy_ticks == 15 && done_cnt == 1, "R5 auto conv", busy_ticks, 15);
    chk(result == 10'h1C3, "R5 auto result", result, 10'h1C3);
    chk(sh_sample == 1, "R3 restart", sh_sample, 1);
    enable = 0; cyc(0); cyc(0);
    auto_cnt = 5'd0; enable = 1; samp_req = 1;
    cyc(0);
    samp_req = 0; clr();
    run(1);
    chk(samp_ticks == 1 && busy, "R3 zero count as one", samp_ticks, 1);
    enable = 0; cyc(0); run(3);
  endtask

  task automatic t_event(input logic [2:0] sel, input bit use_tmr);
    trig_sel = sel; enable = 1; samp_req = 1;
    cyc(0);
    samp_req = 0;
    cyc(0); cyc(0);
    chk(sh_sample && !busy, "R4 release ignored", {sh_sample, busy}, 2);
    if (use_tmr) ext_evt = 1; else timer_evt = 1;
    cyc(0);
    ext_evt = 0; timer_evt = 0;
    cyc(0);
    chk(!busy && sh_sample, "R4 other event ignored", busy, 0);
    if (use_tmr) timer_evt = 1; else ext_evt = 1;
    cyc(0);
    ext_evt = 0; timer_evt = 0;
    chk(busy == 1, "R4 selected event", busy, 1);
    run(16);
    enable = 0; cyc(0);
  endtask

  task automatic t_reserved();
    trig_sel = 3'd4; enable = 1; samp_req = 1;
    cyc(0);
    samp_req = 0; timer_evt = 1; ext_evt = 1;
    run(3);
    timer_evt = 0; ext_evt = 0;
    chk(!busy && sh_sample, "R4 reserved code", busy, 0);
    enable = 0; cyc(0); cyc(0);
  endtask

  task automatic t_abort();
    bus_wdata = 10'h155; bus_wr = 1;
    cyc(0);
    bus_wr = 0;
    cyc(0);
    chk(result == 10'h155, "R9 bus write", result, 10'h155);
    trig_sel = 3'd0; enable = 1; samp_req = 1; adc_in = 10'h0AA;
    cyc(0); cyc(0);
    samp_req = 0;
    cyc(0);
    run(5);
    enable = 0; clr();
    cyc(0);
    chk(!busy && !sh_sample, "R6 stopped", {busy, sh_sample}, 0);
    enable = 1; samp_req = 1;
    cyc(0); cyc(0); cyc(0);
    chk(sh_sample == 0, "R8 no sample before ticks", sh_sample, 0);
    cyc(1); cyc(0); cyc(0);
    chk(sh_sample == 0, "R8 one tick", sh_sample, 0);
    cyc(1); cyc(0);
    chk(sh_sample == 0, "R8 second tick edge", sh_sample, 0);
    cyc(0);
    chk(sh_sample == 1, "R8 sample after recovery", sh_sample, 1);
    chk(done_cnt == 0 && result == 10'h155, "R6 buffer kept", result, 10'h155);
    samp_req = 0;
    cyc(0);
    run(16);
    chk(result == 10'h0AA, "R9 conversion overwrites", result, 10'h0AA);
  endtask

  task automatic t_priority();
    trig_sel = 3'd7; auto_cnt = 5'd1; enable = 1; samp_req = 1;
    cyc(0);
    samp_req = 0;
    cyc(0);
    chk(sh_sample == 1, "R7 setup", sh_sample, 1);
    cyc(1);
    enable = 0;
    cyc(0);
    chk(!busy && !sh_sample, "R7 clear wins", busy, 0);
    cyc(0);
    chk(!busy, "R7 still idle", busy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc(0);
    t_reset();
    t_software();
    t_auto();
    t_event(3'd1, 1'b1);
    t_event(3'd2, 1'b0);
    t_reserved();
    t_abort();
    t_priority();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule